// File: doc/BRIEF.md
# Time-of-Day Seconds Counter

This block keeps a 32-bit count of elapsed seconds and presents it through a narrow 16-bit register port. An external one-second strobe advances the count. Software reads the count as two 16-bit halves at separate offsets. A single 32-bit register holds the count, so a carry from the low half into the high half lands in both halves on the same edge. Software can therefore read the high half, then the low half, and read again if the high half moved in between.

Setting the count needs an unlock step. Software first sets a one-bit unlock flag through its own offset. While that flag is set, a write to the low half replaces bits 15:0. A write to the high half replaces bits 31:16 and clears the flag again. While the flag is clear, writes to either half have no effect. Reads are registered: the value requested in one cycle appears on `rdata_o` in the next cycle, and it stays there until the next read.

Top module: `rtc_seconds_counter`

## Requirements
- R1: After synchronous reset the count is 0x5BFC8900, the unlock flag is 0 and `rdata_o` is 0.
- R2: When `tick_i` is high and no accepted half write occurs in that cycle, the count rises by exactly one. A carry from bit 15 into bit 16 shows in both halves on the same edge.
- R3: A read (`rd_en_i`) samples the state as it stands before the edge. Offset 0 returns bits 31:16, offset 1 returns bits 15:0 and offset 2 returns the unlock flag in bit 0 with zeros above it. The data is on `rdata_o` one cycle after the request and holds while `rd_en_i` is low.
- R4: A read of offset 3 returns zero.
- R5: A write to offset 2 stores only `wdata_i[0]` as the unlock flag.
- R6: With the flag set, a write to offset 1 replaces bits 15:0, leaves bits 31:16 unchanged and leaves the flag set.
- R7: With the flag set, a write to offset 0 replaces bits 31:16, leaves bits 15:0 unchanged and clears the flag.
- R8: With the flag clear, writes to offset 0 or offset 1 leave the count unchanged, apart from any tick in the same cycle.
- R9: If a tick and an accepted half write occur in the same cycle, the written half takes the new data and the other half keeps its value, without the increment.
- R10: A tick at count 0xFFFFFFFF wraps the count to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (2) | Register offset: 0 high half, 1 low half, 2 unlock flag |
| wdata_i | input | CNT_W/2 (16) | Write data |
| rdata_o | output | CNT_W/2 (16) | Registered read data |

## Verification
Every write and tick changes the count on the edge where it is presented. A read returns the pre-edge state on `rdata_o` one register later, so a read issued in the cycle after a write is the first read that can see the write. The bench drives inputs on the falling edge. It computes the expected read value from its model before it applies that edge's update, and it compares `rdata_o` shortly after the rising edge that captured the read. Tick and write collisions, the carry at bit 16, the full wrap and locked writes are driven directly. Mixed random traffic then runs against the same model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFF_HI = 0;
  localparam int OFF_LO = 1;
  localparam int OFF_EN = 2;

  typedef struct packed {
    logic ld_hi;
    logic ld_lo;
  } rtc_load_t;
endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output rtc_load_t         load,
  output logic              unlock_q
);
  logic sel_hi, sel_lo, sel_en;

  always_comb begin
    sel_hi     = (addr == ADDR_W'(OFF_HI));
    sel_lo     = (addr == ADDR_W'(OFF_LO));
    sel_en     = (addr == ADDR_W'(OFF_EN));
    load.ld_hi = wr_en && sel_hi && unlock_q;
    load.ld_lo = wr_en && sel_lo && unlock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q <= 1'b0;
    end else if (wr_en && sel_en) begin
      unlock_q <= wdata[0];
    end else if (load.ld_hi) begin
      unlock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int               CNT_W     = 32,
  parameter logic [CNT_W-1:0] RESET_VAL = 32'h5BFC_8900
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               ld_hi,
  input  logic               ld_lo,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0]   cnt_q
);
  localparam int HALF_W = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RESET_VAL;
    end else if (ld_hi) begin
      cnt_q <= {wdata, cnt_q[HALF_W-1:0]};
    end else if (ld_lo) begin
      cnt_q <= {cnt_q[CNT_W-1:HALF_W], wdata};
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtc_rd_port.sv
module rtc_rd_port
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               unlock,
  output logic [CNT_W/2-1:0] rdata_q
);
  localparam int HALF_W = CNT_W / 2;
  logic [HALF_W-1:0] mux_d;

  always_comb begin
    if (addr == ADDR_W'(OFF_HI))      mux_d = cnt[CNT_W-1:HALF_W];
    else if (addr == ADDR_W'(OFF_LO)) mux_d = cnt[HALF_W-1:0];
    else if (addr == ADDR_W'(OFF_EN)) mux_d = {{(HALF_W-1){1'b0}}, unlock};
    else                              mux_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= mux_d;
  end
endmodule

// File: rtl/rtc_seconds_counter.sv
module rtc_seconds_counter
  import rtc_pkg::*;
#(
  parameter int               ADDR_W    = 2,
  parameter int               CNT_W     = 32,
  parameter logic [CNT_W-1:0] RESET_VAL = 32'h5BFC_8900
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  output logic [CNT_W/2-1:0] rdata_o
);
  localparam int HALF_W = CNT_W / 2;

  rtc_load_t        load;
  logic             unlock_q;
  logic [CNT_W-1:0] cnt_q;

  rtc_wr_gate #(.ADDR_W(ADDR_W), .DATA_W(HALF_W)) u_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .load(load), .unlock_q(unlock_q)
  );

  rtc_count #(.CNT_W(CNT_W), .RESET_VAL(RESET_VAL)) u_count (
    .clk(clk), .rst(rst), .tick(tick_i), .ld_hi(load.ld_hi),
    .ld_lo(load.ld_lo), .wdata(wdata_i), .cnt_q(cnt_q)
  );

  rtc_rd_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en_i), .addr(addr_i),
    .cnt(cnt_q), .unlock(unlock_q), .rdata_q(rdata_o)
  );
endmodule

// File: rtl/rtc_seconds_counter_chk.sv
module rtc_seconds_counter_chk #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [CNT_W/2-1:0] wdata_i,
  input logic [CNT_W/2-1:0] rdata_o,
  input logic [CNT_W-1:0]   cnt,
  input logic               unlock
);
  localparam int HALF_W = CNT_W / 2;
  logic at_hi, at_lo, at_en;
  assign at_hi = (addr_i == ADDR_W'(0));
  assign at_lo = (addr_i == ADDR_W'(1));
  assign at_en = (addr_i == ADDR_W'(2));

  a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !(wr_en_i && unlock && (at_hi || at_lo)))
      |=> cnt == $past(cnt) + CNT_W'(1));

  a_r5_unlock_bit0: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && at_en) |=> unlock == $past(wdata_i[0]));

  a_r6_lo_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && at_lo && unlock)
      |=> cnt[HALF_W-1:0] == $past(wdata_i) && $stable(cnt[CNT_W-1:HALF_W]) && unlock);

  a_r7_hi_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && at_hi && unlock)
      |=> cnt[CNT_W-1:HALF_W] == $past(wdata_i) && $stable(cnt[HALF_W-1:0]) && !unlock);

  a_r8_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (at_hi || at_lo) && !unlock && !tick_i) |=> $stable(cnt));

  a_r4_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !at_hi && !at_lo && !at_en) |=> rdata_o == '0);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind rtc_seconds_counter rtc_seconds_counter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt(cnt_q), .unlock(unlock_q)
);

// File: tb/rtc_seconds_counter_test.sv
module rtc_seconds_counter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] m_cnt;
  logic        m_unl;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_seconds_counter uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_cnt[31:16];
      2'd1:    return m_cnt[15:0];
      2'd2:    return {15'b0, m_unl};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive on falling edge, model update at rising edge, compare after it.
  task automatic step(input string req, input logic t, input logic w, input logic r,
                      input logic [1:0] a, input logic [15:0] d);
    logic [15:0] e;
    @(negedge clk);
    tick_i = t; wr_en_i = w; rd_en_i = r; addr_i = a; wdata_i = d;
    e = exp_read(a);
    @(posedge clk);
    if (w && a == 2'd2)                m_unl = d[0];
    if (w && a == 2'd0 && m_unl)       begin m_cnt[31:16] = d; m_unl = 1'b0; end
    else if (w && a == 2'd1 && m_unl)  m_cnt[15:0] = d;
    else if (t)                        m_cnt = m_cnt + 32'd1;
    #1;
    if (r) check(req, rdata_o, e);
    @(negedge clk);
    tick_i = 0; wr_en_i = 0; rd_en_i = 0;
  endtask

  task automatic rd(input string req, input logic [1:0] a);
    step(req, 1'b0, 1'b0, 1'b1, a, 16'h0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step("wr", 1'b0, 1'b1, 1'b0, a, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    m_cnt = 32'h5BFC_8900; m_unl = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 rdata after reset", rdata_o, 16'h0);
    @(negedge clk) rst = 1'b0;

    rd("R1 R3 high half", 2'd0);
    rd("R1 R3 low half", 2'd1);
    rd("R1 unlock flag", 2'd2);
    rd("R4 undefined offset", 2'd3);

    wr(2'd1, 16'h1111);                // R8: locked
    rd("R8 low locked", 2'd1);
    wr(2'd0, 16'h2222);
    rd("R8 high locked", 2'd0);

    wr(2'd2, 16'hFFFE);                // R5: bit0 only
    rd("R5 flag from bit0=0", 2'd2);
    wr(2'd2, 16'h0003);
    rd("R5 flag set", 2'd2);

    wr(2'd1, 16'hFFFF);                // R6
    rd("R6 flag still set", 2'd2);
    rd("R6 low written", 2'd1);
    wr(2'd0, 16'h0000);                // R7
    rd("R7 flag cleared", 2'd2);
    rd("R7 high written", 2'd0);
    rd("R7 low kept", 2'd1);

    step("R2 tick", 1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
    rd("R2 carry high", 2'd0);
    rd("R2 carry low", 2'd1);

    wr(2'd2, 16'h1); wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'hFFFF);
    step("R10 tick", 1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
    rd("R10 wrap high", 2'd0);
    rd("R10 wrap low", 2'd1);

    wr(2'd2, 16'h1);
    step("R9 lo+tick", 1'b1, 1'b1, 1'b0, 2'd1, 16'hFFFF);
    rd("R9 low wins", 2'd1);
    rd("R9 high kept", 2'd0);
    step("R9 hi+tick", 1'b1, 1'b1, 1'b0, 2'd0, 16'hABCD);
    rd("R9 high wins", 2'd0);
    rd("R9 low kept no carry", 2'd1);

    step("R3 hold", 1'b1, 1'b0, 1'b0, 2'd1, 16'h0);
    #1 check("R3 rdata holds", rdata_o, 16'hFFFF);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  a = 2'($urandom_range(0, 3));
      logic        t = ($urandom_range(0, 99) < 30);
      logic        w = ($urandom_range(0, 99) < 35);
      logic        r = ($urandom_range(0, 99) < 60);
      logic [15:0] d = 16'($urandom());
      if (($urandom_range(0, 99) < 10)) d[15:2] = 14'h3FFF;
      step("R2 R3 R6 R7 R8 R9 random", t, w, r, a, d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule